// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Unit

This block collects the interrupt causes of an Ethernet MAC into one 32-bit sticky event register. A second 32-bit register, the enable mask, selects which causes may raise the single interrupt line. Transmit, receive, DMA and management-interface logic report their events as one-cycle pulses. Software reads both registers through a small register port. It acknowledges an event by writing 1 to its bit. Writing 0 to a bit of the event register does nothing to it.

Two events drive further behaviour. A recorded system bus error produces a one-cycle MAC-disable pulse, which the MAC control logic uses to drop its enable and halt frame processing. The stop-complete event is generated inside the block. A graceful-stop tracker remembers stop requests from three sources: a software stop level, a pause-transmit request level, and a pulse for each valid full-duplex pause frame received. It reports completion once the transmitter is no longer in the middle of a frame.

Top module: `mac_irq_unit`

## Requirements
- R1: After reset the event register and the mask register both read 0, `irq_o` is low and `mac_disable_o` is low.
- R2: A one-cycle pulse on an event input sets its event bit at the clock edge that ends the pulse. The bit then stays set until software clears it. Bit positions: heartbeat 31, receive babble 30, transmit babble 29, stop complete 28, transmit frame 27, transmit buffer 26, receive frame 25, receive buffer 24, management done 23, bus error 22, late collision 21, retry limit 20, transmit underrun 19.
- R3: Writing the event register (`reg_wr_sel_i`=0) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a write-1-to-clear reach the same bit in the same cycle, the bit ends up set.
- R5: Writes to the mask register (`reg_wr_sel_i`=1) store bits 31..19, and reading it returns them. Bits 18..0 of both registers always read 0, and writes to those bits are ignored. Read select: `reg_rd_sel_i`=0 selects the event register and 1 selects the mask register.
- R6: `irq_o` is high exactly when some bit is set in both the event register and the mask register. It drops after a write-1-to-clear of that event bit, or after a write of 0 to the matching mask bit.
- R7: `mac_disable_o` is high for exactly the one cycle that follows each cycle in which `ev_bus_err_i` is high.
- R8: A stop request from any source sets stop-complete (bit 28) only at a clock edge where `tx_in_frame_i` is low. If the transmitter is idle when the request arrives, the bit is set at the very next edge. If a frame is in progress, the request is held until the frame ends.
- R9: The level requests `stop_sw_i` and `stop_pause_i` act on their rising edge only, so holding one high does not set stop-complete again after it has been cleared. Each `pause_frame_i` pulse is a separate request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 1 | Write target: 0 event, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_sel_i | input | 1 | Read source: 0 event, 1 mask |
| reg_rdata_o | output | 32 | Read data (combinational) |
| ev_heartbeat_i | input | 1 | Heartbeat error pulse |
| ev_rx_babble_i | input | 1 | Oversized received frame pulse |
| ev_tx_babble_i | input | 1 | Oversized transmitted frame pulse |
| ev_tx_frame_i | input | 1 | Frame transmitted pulse |
| ev_tx_buf_i | input | 1 | Transmit descriptor updated pulse |
| ev_rx_frame_i | input | 1 | Frame received pulse |
| ev_rx_buf_i | input | 1 | Receive descriptor (not last) updated pulse |
| ev_mgmt_done_i | input | 1 | Management transfer finished pulse |
| ev_bus_err_i | input | 1 | System bus error during DMA pulse |
| ev_late_col_i | input | 1 | Late collision pulse |
| ev_retry_lim_i | input | 1 | Collision retry limit pulse |
| ev_tx_underrun_i | input | 1 | Transmit FIFO underrun pulse |
| stop_sw_i | input | 1 | Software graceful-stop level |
| stop_pause_i | input | 1 | Pause-transmit request level |
| pause_frame_i | input | 1 | Valid pause frame received pulse |
| tx_in_frame_i | input | 1 | Transmitter is mid-frame |
| irq_o | output | 1 | Interrupt request |
| mac_disable_o | output | 1 | One-cycle MAC disable pulse |

## Verification
A wrong event bit shows on the read port one cycle after the pulse that should have set it. It also shows on `irq_o` in the same cycle, as soon as that bit is unmasked. A stop-tracker fault is visible only through bit 28. An early completion appears while `tx_in_frame_i` is still high. A lost request leaves the bit clear after the frame ends. A retriggering level sets the bit again after it has been cleared. The bench sweeps every event input, every mask bit and every stop source. It reads both registers after each step, so a fault is seen within one cycle of the stimulus that exposes it.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int REG_W   = 32;
  localparam int EVT_LO  = 19;
  localparam int EVT_CNT = 13;

  // bit positions (decoded by software, so fixed)
  localparam int B_HEARTBEAT = 31;
  localparam int B_RX_BABBLE = 30;
  localparam int B_TX_BABBLE = 29;
  localparam int B_STOP_DONE = 28;
  localparam int B_TX_FRAME  = 27;
  localparam int B_TX_BUF    = 26;
  localparam int B_RX_FRAME  = 25;
  localparam int B_RX_BUF    = 24;
  localparam int B_MGMT_DONE = 23;
  localparam int B_BUS_ERR   = 22;
  localparam int B_LATE_COL  = 21;
  localparam int B_RETRY_LIM = 20;
  localparam int B_UNDERRUN  = 19;

  typedef enum logic {SEL_EVENT = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  // contiguous field of implemented bits
  function automatic logic [REG_W-1:0] field_mask(input int lo, input int cnt);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (i >= lo && i < lo + cnt) m[i] = 1'b1;
    return m;
  endfunction

  // sticky update: clear first, then set, so a set always wins
  function automatic logic [REG_W-1:0] sticky_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] set,
                                                   input logic [REG_W-1:0] clr,
                                                   input logic [REG_W-1:0] impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

  function automatic logic any_pending(input logic [REG_W-1:0] evt,
                                       input logic [REG_W-1:0] msk);
    return |(evt & msk);
  endfunction
endpackage

// File: rtl/mac_irq_evt.sv
module mac_irq_evt
  import mac_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) q <= '0;
    else         q <= sticky_next(q, set_i, clr_i, IMPL);
  end

  assign q_o = q;
endmodule

// File: rtl/mac_irq_mask.sv
module mac_irq_mask #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & IMPL;
  end

  assign q_o = q;
endmodule

// File: rtl/mac_irq_stop.sv
module mac_irq_stop #(
  parameter int N_LVL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] req_lvl_i,
  input  logic             req_pulse_i,
  input  logic             busy_i,
  output logic             done_o
);
  localparam int N_SRC = N_LVL + 1;

  logic [N_LVL-1:0] lvl_prev;
  logic [N_SRC-1:0] req_now;
  logic [N_SRC-1:0] pend_q;
  logic             any_req;

  for (genvar g = 0; g < N_LVL; g++) begin : g_edge
    always_ff @(posedge clk_i) begin
      if (!rst_ni) lvl_prev[g] <= 1'b0;
      else         lvl_prev[g] <= req_lvl_i[g];
    end
    assign req_now[g] = req_lvl_i[g] & ~lvl_prev[g];
  end
  assign req_now[N_LVL] = req_pulse_i;

  assign any_req = |(pend_q | req_now);
  assign done_o  = any_req & ~busy_i;

  // requests wait while a frame is in flight; all drain together
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     pend_q <= '0;
    else if (busy_i) pend_q <= pend_q | req_now;
    else             pend_q <= '0;
  end
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit
  import mac_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_wr_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        reg_rd_sel_i,
  output logic [31:0] reg_rdata_o,
  input  logic        ev_heartbeat_i,
  input  logic        ev_rx_babble_i,
  input  logic        ev_tx_babble_i,
  input  logic        ev_tx_frame_i,
  input  logic        ev_tx_buf_i,
  input  logic        ev_rx_frame_i,
  input  logic        ev_rx_buf_i,
  input  logic        ev_mgmt_done_i,
  input  logic        ev_bus_err_i,
  input  logic        ev_late_col_i,
  input  logic        ev_retry_lim_i,
  input  logic        ev_tx_underrun_i,
  input  logic        stop_sw_i,
  input  logic        stop_pause_i,
  input  logic        pause_frame_i,
  input  logic        tx_in_frame_i,
  output logic        irq_o,
  output logic        mac_disable_o
);
  localparam logic [REG_W-1:0] IMPL = field_mask(EVT_LO, EVT_CNT);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] evt_q;
  logic [REG_W-1:0] mask_q;
  logic             stop_done;
  logic             mask_we;
  logic             disable_q;

  mac_irq_stop #(.N_LVL(2)) u_stop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_lvl_i  ({stop_pause_i, stop_sw_i}),
    .req_pulse_i(pause_frame_i),
    .busy_i     (tx_in_frame_i),
    .done_o     (stop_done)
  );

  always_comb begin
    set_vec = '0;
    set_vec[B_HEARTBEAT] = ev_heartbeat_i;
    set_vec[B_RX_BABBLE] = ev_rx_babble_i;
    set_vec[B_TX_BABBLE] = ev_tx_babble_i;
    set_vec[B_STOP_DONE] = stop_done;
    set_vec[B_TX_FRAME]  = ev_tx_frame_i;
    set_vec[B_TX_BUF]    = ev_tx_buf_i;
    set_vec[B_RX_FRAME]  = ev_rx_frame_i;
    set_vec[B_RX_BUF]    = ev_rx_buf_i;
    set_vec[B_MGMT_DONE] = ev_mgmt_done_i;
    set_vec[B_BUS_ERR]   = ev_bus_err_i;
    set_vec[B_LATE_COL]  = ev_late_col_i;
    set_vec[B_RETRY_LIM] = ev_retry_lim_i;
    set_vec[B_UNDERRUN]  = ev_tx_underrun_i;
  end

  assign clr_vec = (reg_wr_i && reg_sel_e'(reg_wr_sel_i) == SEL_EVENT) ? reg_wdata_i : '0;
  assign mask_we = reg_wr_i && reg_sel_e'(reg_wr_sel_i) == SEL_MASK;

  mac_irq_evt #(.W(REG_W), .IMPL(IMPL)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (evt_q)
  );

  mac_irq_mask #(.W(REG_W), .IMPL(IMPL)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(reg_wdata_i),
    .q_o    (mask_q)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) disable_q <= 1'b0;
    else         disable_q <= ev_bus_err_i;
  end

  assign mac_disable_o = disable_q;
  assign irq_o         = any_pending(evt_q, mask_q);
  assign reg_rdata_o   = (reg_sel_e'(reg_rd_sel_i) == SEL_MASK) ? mask_q : evt_q;
endmodule

// File: rtl/mac_irq_chk.sv
module mac_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] set_vec,
  input logic [31:0] clr_vec,
  input logic [31:0] evt_q,
  input logic        mask_we,
  input logic        stop_done,
  input logic        tx_in_frame_i,
  input logic        ev_bus_err_i,
  input logic        mac_disable_o,
  input logic        irq_o
);
  assert_set_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec[31:19]) |=> ((evt_q & $past(set_vec)) == ($past(set_vec) & 32'hFFF8_0000)));

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_vec & clr_vec & 32'hFFF8_0000)) |=> ((evt_q & $past(set_vec & clr_vec)) != 0));

  assert_clear_only_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_q) & ~evt_q & ~$past(clr_vec)) == 0));

  assert_disable_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_bus_err_i |=> mac_disable_o);

  assert_disable_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mac_disable_o) |-> $past(ev_bus_err_i));

  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done |-> !tx_in_frame_i);

  assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|set_vec) || $past(mask_we)));
endmodule

bind mac_irq_unit mac_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .evt_q        (evt_q),
  .mask_we      (mask_we),
  .stop_done    (stop_done),
  .tx_in_frame_i(tx_in_frame_i),
  .ev_bus_err_i (ev_bus_err_i),
  .mac_disable_o(mac_disable_o),
  .irq_o        (irq_o)
);

// File: tb/test_mac_irq_unit.sv
module test_mac_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] hw = '0;
  logic        s_sw = 1'b0, s_pause = 1'b0, p_frame = 1'b0, in_frame = 1'b0;
  logic        irq, mdis;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  mac_irq_unit i_mac_irq_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_wr_sel_i(wsel), .reg_wdata_i(wdata),
    .reg_rd_sel_i(rsel), .reg_rdata_o(rdata),
    .ev_heartbeat_i(hw[0]), .ev_rx_babble_i(hw[1]), .ev_tx_babble_i(hw[2]),
    .ev_tx_frame_i(hw[3]), .ev_tx_buf_i(hw[4]), .ev_rx_frame_i(hw[5]),
    .ev_rx_buf_i(hw[6]), .ev_mgmt_done_i(hw[7]), .ev_bus_err_i(hw[8]),
    .ev_late_col_i(hw[9]), .ev_retry_lim_i(hw[10]), .ev_tx_underrun_i(hw[11]),
    .stop_sw_i(s_sw), .stop_pause_i(s_pause), .pause_frame_i(p_frame),
    .tx_in_frame_i(in_frame), .irq_o(irq), .mac_disable_o(mdis)
  );

  // expected bit position of hw[k], from the requirement table
  function automatic int pos_of(input int k);
    return (k < 3) ? 31 - k : 30 - k;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rsel = sel; #1; v = rdata;
  endtask

  task automatic wreg(input logic sel, input logic [31:0] d);
    wr = 1'b1; wsel = sel; wdata = d; step(); wr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    rd(1'b0, v); check("R1 event", v, 0);
    rd(1'b1, v); check("R1 mask", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 disable", {31'b0, mdis}, 0);

    // R2 / R6 sweep over every hardware event
    for (int k = 0; k < 12; k++) begin
      logic [31:0] b;
      b = 32'h1 << pos_of(k);
      hw[k] = 1'b1; step(); hw[k] = 1'b0;
      rd(1'b0, v); check("R2 set", v, b);
      step(); rd(1'b0, v); check("R2 sticky", v, b);
      check("R6 masked off", {31'b0, irq}, 0);
      wreg(1'b1, b); check("R6 irq on", {31'b0, irq}, 1);
      wreg(1'b1, ~b); check("R6 mask 0 drops", {31'b0, irq}, 0);
      wreg(1'b1, b);
      wreg(1'b0, 32'h0); rd(1'b0, v); check("R3 write 0 no effect", v, b);
      wreg(1'b0, b); rd(1'b0, v); check("R3 w1c", v, 0);
      check("R6 w1c drops", {31'b0, irq}, 0);
    end
    wreg(1'b1, 32'h0);

    // R3 partial clear
    hw = 12'hFFF; step(); hw = '0;
    rd(1'b0, v); check("R2 all", v, 32'hEFF8_0000);
    wreg(1'b0, 32'hA000_0000); rd(1'b0, v); check("R3 partial", v, 32'h4FF8_0000);
    wreg(1'b0, 32'hFFFF_FFFF); rd(1'b0, v); check("R3 all clear", v, 0);

    // R4 set beats clear
    for (int k = 0; k < 12; k++) begin
      hw[k] = 1'b1; wr = 1'b1; wsel = 1'b0; wdata = 32'h1 << pos_of(k);
      step(); hw[k] = 1'b0; wr = 1'b0;
      rd(1'b0, v); check("R4 set wins", v, 32'h1 << pos_of(k));
      wreg(1'b0, 32'hFFFF_FFFF);
    end

    // R5 mask walk and reserved bits
    for (int k = 0; k < 32; k++) begin
      wreg(1'b1, 32'h1 << k); rd(1'b1, v);
      check("R5 mask walk", v, (k >= 19) ? (32'h1 << k) : 32'h0);
    end
    wreg(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); check("R5 mask full", v, 32'hFFF8_0000);
    wreg(1'b1, 32'h0);
    wreg(1'b0, 32'h0007_FFFF); rd(1'b0, v); check("R5 event reserved", v, 0);

    // R7 disable pulse
    hw[8] = 1'b1; step(); hw[8] = 1'b0;
    check("R7 pulse", {31'b0, mdis}, 1);
    step(); check("R7 one cycle", {31'b0, mdis}, 0);
    wreg(1'b0, 32'hFFFF_FFFF);

    // R8 each stop source, while busy then idle
    for (int s = 0; s < 3; s++) begin
      in_frame = 1'b1;
      if (s == 0) s_sw = 1'b1;
      if (s == 1) s_pause = 1'b1;
      if (s == 2) p_frame = 1'b1;
      step(); p_frame = 1'b0;
      repeat (3) step();
      rd(1'b0, v); check("R8 held while busy", v, 0);
      in_frame = 1'b0; step();
      rd(1'b0, v); check("R8 set after frame", v, 32'h1000_0000);
      wreg(1'b0, 32'h1000_0000);
      // R9 held level does not retrigger
      repeat (3) step();
      rd(1'b0, v); check("R9 no retrigger", v, 0);
      s_sw = 1'b0; s_pause = 1'b0; step();
      // idle request: set at next edge
      if (s == 0) s_sw = 1'b1;
      if (s == 1) s_pause = 1'b1;
      if (s == 2) p_frame = 1'b1;
      step(); p_frame = 1'b0;
      rd(1'b0, v); check("R8 idle immediate", v, 32'h1000_0000);
      wreg(1'b0, 32'h1000_0000);
      s_sw = 1'b0; s_pause = 1'b0; step();
    end

    // R9 a new rising edge triggers again
    s_sw = 1'b1; step(); wreg(1'b0, 32'h1000_0000);
    s_sw = 1'b0; step(); s_sw = 1'b1; step();
    rd(1'b0, v); check("R9 new edge", v, 32'h1000_0000);

    finished = 1'b1;
    finish_run();
  end
endmodule